// File: doc/BRIEF.md
# Per-Block Lock Register File

This block keeps one small lock control register for each of eight equal 64-Kbyte regions of a flash array and applies those settings to host bus accesses. Software selects a register with a 3-bit index and writes it with a strobe and an 8-bit data byte. The register's contents can be read back combinationally through the same index.

Each access request carries a 19-bit byte address and a read/write flag. The block decodes the region from the address and raises a read-permit or a write-permit flag. On a blocked read it replaces the data from the array with zero.

Each register holds three lock bits:
- The read lock blocks reads of its region.
- The write lock rejects program and erase requests to its region.
- The lock-down bit, once set, freezes the write lock and itself until the asynchronous reset is asserted.

Protection and register writes take effect only when the mode input selects bus-interface operation. In programmer mode every access is permitted and data passes through unchanged.

Top module: `blk_lock_regfile`

## Requirements
- R1: After rst_ni is asserted, every register reads 00h. Reads and writes to every region are permitted.
- R2: reg_rdata_o shows the register picked by reg_sel_i. The register's bits are placed as follows:
  - bit 0 is the write lock;
  - bit 1 is lock-down;
  - bit 2 is the read lock;
  - bits 7:3 always read 0, even after a write of ones.
- R3: In bus mode, a read request to a region whose read lock is set gives rd_ok_o = 0 and rd_data_o = 00h. A read to an unlocked region gives rd_ok_o = 1 and rd_data_o = mem_rdata_i.
- R4: In bus mode, a write request to a region whose write lock is set gives wr_ok_o = 0. Without the write lock it gives wr_ok_o = 1.
- R5: Once lock-down is set, writes to that register leave bits 1 and 0 unchanged. Bit 2 still follows the written data.
- R6: Lock-down is cleared only by asserting rst_ni.
- R7: The region is acc_addr_i[18:16]. A region's lock bits do not affect accesses to any other region.
- R8: With bus_mode_i = 0, all lock bits are ignored, so every valid request is permitted and data passes through. Register write strobes in this mode are ignored.
- R9: With acc_valid_i = 0, both permit flags are 0. A read request never raises wr_ok_o, and a write request never raises rd_ok_o.
- R10: A register write takes effect at the rising clock edge on which reg_we_i is high. Readback and permit outputs are combinational on the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | 1 = bus-interface mode (locks enforced), 0 = programmer mode |
| reg_sel_i | input | 3 | Lock register index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Readback of the selected register |
| acc_valid_i | input | 1 | Access request present |
| acc_addr_i | input | 19 | Access byte address |
| acc_write_i | input | 1 | 1 = program/erase request, 0 = read request |
| mem_rdata_i | input | 8 | Data read from the array |
| rd_ok_o | output | 1 | Read permitted |
| rd_data_o | output | 8 | Read data, forced to 00h when blocked |
| wr_ok_o | output | 1 | Program/erase permitted |

## Verification
Register updates land on the rising edge that samples the write strobe. Every other result is due in the same cycle as its stimulus, with zero added latency.

The bench changes inputs on the falling edge and samples outputs 1 ns later, well before the next rising edge. A dedicated check confirms that a strobed write is still invisible before its edge and visible after it.

Lock-down stickiness and the zero substitution are tracked continuously by the bound checker.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef struct packed {
    logic rlock;  // bit 2
    logic ldown;  // bit 1
    logic wlock;  // bit 0
  } lock_t;
  localparam int LOCK_W = 3;
endpackage

// File: rtl/blk_lock_reg.sv
module blk_lock_reg
  import blk_lock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  wdata_i,
  output lock_t       lock_o
);
  lock_t lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
    end else if (wr_en_i) begin
      lock_q.rlock <= wdata_i[2];
      // lock-down freezes bits 1:0 until reset
      if (!lock_q.ldown) begin
        lock_q.ldown <= wdata_i[1];
        lock_q.wlock <= wdata_i[0];
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/blk_lock_decode.sv
module blk_lock_decode #(
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16,
  parameter int NUM_BLKS  = 8,
  localparam int SEL_W    = $clog2(NUM_BLKS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEL_W-1:0]  idx_o
);
  logic unused_addr;
  assign unused_addr = ^addr_i;
  assign idx_o = addr_i[BLK_SHIFT +: SEL_W];
endmodule

// File: rtl/blk_lock_gate.sv
module blk_lock_gate
  import blk_lock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              bus_mode_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  lock_t             lock_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_ok_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ok_o
);
  logic rd_req, wr_req, rd_block, wr_block;

  always_comb begin
    rd_req   = acc_valid_i && !acc_write_i;
    wr_req   = acc_valid_i &&  acc_write_i;
    rd_block = bus_mode_i && lock_i.rlock;
    wr_block = bus_mode_i && lock_i.wlock;
    rd_ok_o  = rd_req && !rd_block;
    wr_ok_o  = wr_req && !wr_block;
    rd_data_o = rd_block ? '0 : mem_rdata_i;
  end
endmodule

// File: rtl/blk_lock_regfile.sv
module blk_lock_regfile
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLKS  = 8,
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16,
  parameter int DATA_W    = 8,
  localparam int SEL_W    = $clog2(NUM_BLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_mode_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_ok_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ok_o
);
  lock_t               lock_q [NUM_BLKS];
  logic [NUM_BLKS-1:0] rlock_q, ldown_q, wlock_q;
  logic [SEL_W-1:0]    acc_idx;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:LOCK_W];

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    logic wr_en;
    assign wr_en = reg_we_i && bus_mode_i && (reg_sel_i == SEL_W'(b));
    blk_lock_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(wr_en),
      .wdata_i(reg_wdata_i[LOCK_W-1:0]),
      .lock_o (lock_q[b])
    );
    assign rlock_q[b] = lock_q[b].rlock;
    assign ldown_q[b] = lock_q[b].ldown;
    assign wlock_q[b] = lock_q[b].wlock;
  end

  assign reg_rdata_o = {{(DATA_W-LOCK_W){1'b0}}, lock_q[reg_sel_i]};

  blk_lock_decode #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NUM_BLKS(NUM_BLKS)
  ) u_dec (
    .addr_i(acc_addr_i),
    .idx_o (acc_idx)
  );

  blk_lock_gate #(.DATA_W(DATA_W)) u_gate (
    .bus_mode_i (bus_mode_i),
    .acc_valid_i(acc_valid_i),
    .acc_write_i(acc_write_i),
    .lock_i     (lock_q[acc_idx]),
    .mem_rdata_i(mem_rdata_i),
    .rd_ok_o    (rd_ok_o),
    .rd_data_o  (rd_data_o),
    .wr_ok_o    (wr_ok_o)
  );
endmodule

// File: rtl/blk_lock_regfile_chk.sv
module blk_lock_regfile_chk #(
  parameter int NUM_BLKS = 8,
  parameter int DATA_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_mode_i,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              rd_ok_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_ok_o,
  input logic [NUM_BLKS-1:0] ldown_q,
  input logic [NUM_BLKS-1:0] wlock_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DATA_W-1:3] == '0); // R2

  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && !rd_ok_o) |-> (rd_data_o == '0)); // R3

  AST_WLOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(wlock_q) ^ wlock_q) & $past(ldown_q)) == '0)); // R5

  AST_LDOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ldown_q) & ~ldown_q) == '0)); // R6

  AST_PROG_MODE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_mode_i && acc_valid_i) |-> (rd_ok_o || wr_ok_o)); // R8

  AST_PERMIT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_ok_o && wr_ok_o)); // R9

  AST_IDLE_NO_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!rd_ok_o && !wr_ok_o)); // R9
endmodule

bind blk_lock_regfile blk_lock_regfile_chk #(.NUM_BLKS(NUM_BLKS), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_mode_i (bus_mode_i),
  .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i),
  .reg_rdata_o(reg_rdata_o),
  .rd_ok_o    (rd_ok_o),
  .rd_data_o  (rd_data_o),
  .wr_ok_o    (wr_ok_o),
  .ldown_q    (ldown_q),
  .wlock_q    (wlock_q)
);

// File: tb/blk_lock_regfile_bench.sv
`timescale 1ns/1ps
module blk_lock_regfile_bench;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        bus_mode_i = 1;
  logic [2:0]  reg_sel_i = 0;
  logic        reg_we_i = 0;
  logic [7:0]  reg_wdata_i = 0;
  logic [7:0]  reg_rdata_o;
  logic        acc_valid_i = 0;
  logic [18:0] acc_addr_i = 0;
  logic        acc_write_i = 0;
  logic [7:0]  mem_rdata_i = 8'hA5;
  logic        rd_ok_o;
  logic [7:0]  rd_data_o;
  logic        wr_ok_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  blk_lock_regfile u_blk_lock_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_mode_i(bus_mode_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .acc_write_i(acc_write_i), .mem_rdata_i(mem_rdata_i), .rd_ok_o(rd_ok_o),
    .rd_data_o(rd_data_o), .wr_ok_o(wr_ok_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] sel, logic [7:0] data);
    @(negedge clk_i);
    reg_sel_i = sel; reg_wdata_i = data; reg_we_i = 1;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic reg_read(logic [2:0] sel, output logic [7:0] val);
    reg_sel_i = sel; #1; val = reg_rdata_o;
  endtask

  // returns {rd_ok, wr_ok, rd_data}
  task automatic access(logic [18:0] addr, logic wr, output logic rok, output logic wok,
                        output logic [7:0] d);
    acc_valid_i = 1; acc_addr_i = addr; acc_write_i = wr; #1;
    rok = rd_ok_o; wok = wr_ok_o; d = rd_data_o;
    acc_valid_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic t_reset();
    logic [7:0] v; logic rok, wok;
    for (int b = 0; b < 8; b++) begin
      reg_read(3'(b), v); check("R1 reg after reset", v, 8'h00);
      access({3'(b), 16'h0040}, 0, rok, wok, v); check("R1 read permitted", {7'd0, rok}, 8'd1);
      access({3'(b), 16'h0040}, 1, rok, wok, v); check("R1 write permitted", {7'd0, wok}, 8'd1);
    end
  endtask

  task automatic t_readback();
    logic [7:0] v;
    reg_write(3, 8'hFD); reg_read(3, v); check("R2 readback reserved zero", v, 8'h05);
    reg_write(2, 8'h00); reg_read(2, v); check("R2 readback other reg", v, 8'h00);
  endtask

  task automatic t_locks();
    logic [7:0] d; logic rok, wok;
    access(19'h3_1234, 0, rok, wok, d);
    check("R3 locked read ok", {7'd0, rok}, 8'd0); check("R3 locked read data", d, 8'h00);
    access(19'h3_FFFF, 1, rok, wok, d); check("R4 locked write", {7'd0, wok}, 8'd0);
    access(19'h2_FFFF, 0, rok, wok, d);
    check("R7 neighbour read ok", {7'd0, rok}, 8'd1); check("R7 neighbour data", d, 8'hA5);
    access(19'h4_0000, 1, rok, wok, d); check("R7 neighbour write", {7'd0, wok}, 8'd1);
  endtask

  task automatic t_lockdown();
    logic [7:0] v; logic rok, wok;
    reg_write(5, 8'h03); reg_read(5, v); check("R5 set lock-down", v, 8'h03);
    reg_write(5, 8'h00); reg_read(5, v); check("R5 frozen bits", v, 8'h03);
    reg_write(5, 8'h04); reg_read(5, v); check("R5 read lock still writable", v, 8'h07);
    access(19'h5_0010, 1, rok, wok, v); check("R4 write under lock-down", {7'd0, wok}, 8'd0);
    do_reset();
    reg_read(5, v); check("R6 reset clears lock-down", v, 8'h00);
    reg_write(5, 8'h01); reg_write(5, 8'h00); reg_read(5, v);
    check("R6 bits writable after reset", v, 8'h00);
  endtask

  task automatic t_prog_mode();
    logic [7:0] v; logic rok, wok;
    reg_write(1, 8'h05);
    @(negedge clk_i); bus_mode_i = 0;
    access(19'h1_0000, 0, rok, wok, v);
    check("R8 read unlocked in prog mode", {7'd0, rok}, 8'd1); check("R8 data pass", v, 8'hA5);
    access(19'h1_0000, 1, rok, wok, v); check("R8 write in prog mode", {7'd0, wok}, 8'd1);
    reg_write(6, 8'h01); reg_read(6, v); check("R8 reg write ignored", v, 8'h00);
    @(negedge clk_i); bus_mode_i = 1;
    access(19'h1_0000, 1, rok, wok, v); check("R4 lock back in bus mode", {7'd0, wok}, 8'd0);
  endtask

  task automatic t_idle();
    logic rok, wok;
    acc_valid_i = 0; acc_addr_i = 19'h0_0000; #1;
    check("R9 idle rd_ok", {7'd0, rd_ok_o}, 8'd0); check("R9 idle wr_ok", {7'd0, wr_ok_o}, 8'd0);
    acc_valid_i = 1; acc_write_i = 0; #1;
    check("R9 read gives no wr_ok", {7'd0, wr_ok_o}, 8'd0);
    acc_write_i = 1; #1;
    check("R9 write gives no rd_ok", {7'd0, rd_ok_o}, 8'd0);
    acc_valid_i = 0;
    rok = 0; wok = 0;
  endtask

  task automatic t_timing();
    logic [7:0] v;
    @(negedge clk_i);
    reg_sel_i = 7; reg_wdata_i = 8'h04; reg_we_i = 1; #1;
    check("R10 not visible before edge", reg_rdata_o, 8'h00);
    @(negedge clk_i); reg_we_i = 0; #1;
    v = reg_rdata_o; check("R10 visible after edge", v, 8'h04);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_readback();
    t_locks();
    t_lockdown();
    t_prog_mode();
    t_idle();
    t_timing();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule